// File: doc/BRIEF.md
# Serial Sample Output Formatter

This block turns a converter result of 1 to 32 bits into a serial frame. It sends that frame out on one or two data lanes, one bit per lane for each shift-clock edge. A byte-wide configuration register controls the output. It sets whether the frame is the raw result length or padded to a processor-friendly 16 or 32 bits. It sets whether padding zeros go after or before the data. It also sets whether one lane or two lanes are used, and whether two lanes interleave bit by bit or split the frame into halves.

The frame is captured when chip select falls. Each strobe on `shift_stb` marks one shift-clock edge and moves both lanes on by one bit, most significant bit first. `frame_done` pulses once the longer lane is exhausted. While chip select is high the lanes are released, which is shown by `sdo_oe` low. The register starts locked and only accepts writes while `cfg_unlock` is high and no frame is in progress.

Top module: `sdo_formatter`

## Requirements
- R1: After reset `cfg_rdata` is 0x00 and `sdo`, `sdo_oe` and `frame_done` are all 0.
- R2: A write is accepted only while `cfg_unlock` is high; otherwise `cfg_rdata` is unchanged. Field layout: bit 6 padded mode, bit 5 right alignment, bit 4 half split, bit 2 two-lane, bits 1:0 protocol code. Bits 7 and 3 always read 0.
- R3: A write whose protocol code (bits 1:0) is 01 or 10 is rejected and the register keeps its old value; codes 00 and 11 are stored.
- R4: A write while `cs_n` is low has no effect on the register.
- R5: With padded mode off the frame length L equals `data_len`; with it on, L is 16 when `data_len` ≤ 16 and 32 otherwise.
- R6: In padded mode with bit 5 clear, the `data_len` data bits (MSB first) lead and zeros follow. With bit 5 set, L−N zeros lead and the data follows. Bit 5 has no effect with padded mode off.
- R7: With bit 2 clear, all L frame bits leave on `sdo[0]` over L strobes and `sdo[1]` stays 0.
- R8: With bit 2 set and not both bits 6 and 4 set, `sdo[1]` carries frame bits 0, 2, 4, … and `sdo[0]` carries bits 1, 3, 5, … over ceil(L/2) strobes. When L is odd, `sdo[0]` is 0 on the last one.
- R9: With bits 6, 4 and 2 all set, `sdo[1]` carries the first L/2 frame bits and `sdo[0]` the last L/2, over L/2 strobes. Bit 4 is ignored in every other case.
- R10: The first bit of each lane appears in the cycle after the clock edge that samples `cs_n` low. Each edge that samples `shift_stb` high advances the lanes by one bit.
- R11: `frame_done` is high for exactly the one cycle after the edge that takes the last strobe of the frame. From then on both lanes drive 0.
- R12: While `cs_n` is high, `sdo_oe` is low (from the next cycle) and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_unlock | input | 1 | Write permission level |
| cfg_rdata | output | 8 | Current register value |
| data_in | input | 32 | Result word, data in the low `data_len` bits |
| data_len | input | 6 | Result length N, 1 to 32 |
| cs_n | input | 1 | Active-low chip select |
| shift_stb | input | 1 | One-cycle strobe per shift-clock edge |
| sdo | output | 2 | Lane 1 (bit 1) and lane 0 (bit 0) serial data |
| sdo_oe | output | 1 | Lane drive enable |
| frame_done | output | 1 | Pulse after the final bit |

## Verification
The frames are drawn from a table of configurations crossed with lengths and data words.
- Short, odd and full-width lengths separate the raw frame from the 16-bit and 32-bit padded frames.
- One pattern is run with left and right alignment, which exposes a misplaced pad. A right-align setting with padded mode off shows that the bit is ignored.
- In two-lane runs, odd lengths expose the tail of the shorter lane. Enabling the half split without padded mode, or without two lanes, proves it falls back to interleave or single-lane output.
- Directed sequences cover the write lock, the rejected protocol codes and writes during a frame.

// File: rtl/sdo_fmt_pkg.sv
package sdo_fmt_pkg;

    localparam logic [1:0] PROTO_SPI    = 2'b00;
    localparam logic [1:0] PROTO_RETIME = 2'b11;

    typedef struct packed {
        logic       padded;
        logic       ralign;
        logic       halfsplit;
        logic       dual;
        logic [1:0] proto;
    } sdo_cfg_t;

    function automatic logic [7:0] cfg_pack(sdo_cfg_t c);
        return {1'b0, c.padded, c.ralign, c.halfsplit, 1'b0, c.dual, c.proto};
    endfunction

    function automatic sdo_cfg_t cfg_unpack(logic [7:0] b);
        sdo_cfg_t c;
        c.padded    = b[6];
        c.ralign    = b[5];
        c.halfsplit = b[4];
        c.dual      = b[2];
        c.proto     = b[1:0];
        return c;
    endfunction

endpackage

// File: rtl/sdo_cfg_reg.sv
module sdo_cfg_reg
    import sdo_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       unlock,
    input  logic       cs_n,
    output logic [7:0] rdata
);

    sdo_cfg_t cfg_d, cfg_q;
    logic     code_ok;

    always_comb begin
        code_ok = (wdata[1:0] == PROTO_SPI) || (wdata[1:0] == PROTO_RETIME);
        cfg_d   = cfg_q;
        if (wr_en && unlock && cs_n && code_ok) begin
            cfg_d = cfg_unpack(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rdata = cfg_pack(cfg_q);

    // R2
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlock) |=> $stable(rdata));

    // R3
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata[1:0] == 2'b01 || wdata[1:0] == 2'b10)) |=> $stable(rdata));

    // R4
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cs_n) |=> $stable(rdata));

endmodule

// File: rtl/sdo_frame_build.sv
module sdo_frame_build #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              padded,
    input  logic              ralign,
    input  logic              halfsplit,
    input  logic              dual,
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] lane0,
    output logic [DATA_W-1:0] lane1,
    output logic [LEN_W-1:0]  cycles
);

    localparam int HALF = DATA_W / 2;

    logic [LEN_W-1:0]  nlen, flen, keep_len, lsh;
    logic [DATA_W-1:0] masked, frame, il0, il1;

    always_comb begin
        nlen = (len > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : len;
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = data[i] & (i < int'(nlen));
        end
        if (padded) flen = (nlen <= LEN_W'(HALF)) ? LEN_W'(HALF) : LEN_W'(DATA_W);
        else        flen = nlen;
        keep_len = (padded && ralign) ? flen : nlen;
        lsh      = LEN_W'(DATA_W) - keep_len;
        frame    = masked << lsh;
    end

    // Two-lane interleave: even frame positions to lane 1, odd to lane 0.
    for (genvar k = 0; k < HALF; k++) begin : g_il
        assign il1[DATA_W-1-k] = frame[DATA_W-1-2*k];
        assign il0[DATA_W-1-k] = frame[DATA_W-2-2*k];
    end
    assign il1[HALF-1:0] = '0;
    assign il0[HALF-1:0] = '0;

    always_comb begin
        if (!dual) begin
            lane1  = '0;
            lane0  = frame;
            cycles = flen;
        end else if (padded && halfsplit) begin
            lane1  = frame;
            lane0  = frame << (flen >> 1);
            cycles = flen >> 1;
        end else begin
            lane1  = il1;
            lane0  = il0;
            cycles = (flen + LEN_W'(1)) >> 1;
        end
    end

endmodule

// File: rtl/sdo_lane_shift.sv
module sdo_lane_shift #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              shift_stb,
    input  logic [DATA_W-1:0] ld_lane0,
    input  logic [DATA_W-1:0] ld_lane1,
    input  logic [LEN_W-1:0]  ld_cycles,
    output logic [1:0]        sdo,
    output logic              sdo_oe,
    output logic              frame_done
);

    typedef struct packed {
        logic              cs;
        logic              active;
        logic [DATA_W-1:0] l0;
        logic [DATA_W-1:0] l1;
        logic [LEN_W-1:0]  cnt;
        logic              done;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      live;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.cs   = cs_n;
        if (cs_n) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.cs) begin
            st_d.active = 1'b1;
            st_d.l0     = ld_lane0;
            st_d.l1     = ld_lane1;
            st_d.cnt    = ld_cycles;
        end else if (shift_stb && st_q.active && st_q.cnt != '0) begin
            st_d.l0   = st_q.l0 << 1;
            st_d.l1   = st_q.l1 << 1;
            st_d.cnt  = st_q.cnt - LEN_W'(1);
            st_d.done = (st_q.cnt == LEN_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.cs <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign live       = st_q.active && (st_q.cnt != '0);
    assign sdo        = live ? {st_q.l1[DATA_W-1], st_q.l0[DATA_W-1]} : 2'b00;
    assign sdo_oe     = st_q.active;
    assign frame_done = st_q.done;

    // R12
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sdo_oe && sdo == 2'b00));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R11
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> ($past(shift_stb) && $past(!cs_n)));

endmodule

// File: rtl/sdo_formatter.sv
module sdo_formatter #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_unlock,
    output logic [7:0]        cfg_rdata,
    input  logic [DATA_W-1:0] data_in,
    input  logic [LEN_W-1:0]  data_len,
    input  logic              cs_n,
    input  logic              shift_stb,
    output logic [1:0]        sdo,
    output logic              sdo_oe,
    output logic              frame_done
);

    logic [DATA_W-1:0] ld0, ld1;
    logic [LEN_W-1:0]  ld_cyc;

    sdo_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wdata  (cfg_wdata),
        .unlock (cfg_unlock),
        .cs_n   (cs_n),
        .rdata  (cfg_rdata)
    );

    sdo_frame_build #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_build (
        .padded    (cfg_rdata[6]),
        .ralign    (cfg_rdata[5]),
        .halfsplit (cfg_rdata[4]),
        .dual      (cfg_rdata[2]),
        .data      (data_in),
        .len       (data_len),
        .lane0     (ld0),
        .lane1     (ld1),
        .cycles    (ld_cyc)
    );

    sdo_lane_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .shift_stb  (shift_stb),
        .ld_lane0   (ld0),
        .ld_lane1   (ld1),
        .ld_cycles  (ld_cyc),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .frame_done (frame_done)
    );

endmodule

// File: tb/sdo_formatter_test.sv
`timescale 1ns/1ps
module sdo_formatter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_unlock = 1'b0;
    logic [7:0]  cfg_rdata;
    logic [31:0] data_in = '0;
    logic [5:0]  data_len = '0;
    logic        cs_n = 1'b1;
    logic        shift_stb = 1'b0;
    logic [1:0]  sdo;
    logic        sdo_oe;
    logic        frame_done;

    int checks = 0;
    int fails  = 0;
    int cycles_run = 0;

    always #2 clk = ~clk;

    sdo_formatter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_unlock(cfg_unlock), .cfg_rdata(cfg_rdata), .data_in(data_in),
        .data_len(data_len), .cs_n(cs_n), .shift_stb(shift_stb), .sdo(sdo),
        .sdo_oe(sdo_oe), .frame_done(frame_done)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic [5:0]  n;
        logic [31:0] d;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 6'd12, 32'h0000_0ABC},
        '{8'h20, 6'd5,  32'h0000_0013},
        '{8'h40, 6'd12, 32'h0000_0A5C},
        '{8'h60, 6'd12, 32'h0000_0A5C},
        '{8'h44, 6'd20, 32'h000F_0F35},
        '{8'h54, 6'd12, 32'h0000_09C3},
        '{8'h74, 6'd24, 32'h00C0_FFEE},
        '{8'h04, 6'd7,  32'h0000_005B},
        '{8'h14, 6'd10, 32'h0000_02D1},
        '{8'h03, 6'd32, 32'hDEAD_BEEF},
        '{8'h50, 6'd20, 32'h0009_6A3C}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [7:0] c, input int n, input logic [31:0] d,
                                  output logic [31:0] e0, output logic [31:0] e1,
                                  output int cyc);
        logic [31:0] fb;
        int L;
        bit pm, ra, bs, du;
        pm = c[6]; ra = c[5]; bs = c[4]; du = c[2];
        L = pm ? ((n <= 16) ? 16 : 32) : n;
        fb = '0;
        for (int i = 0; i < L; i++) begin
            if (pm && ra) fb[i] = (i < L - n) ? 1'b0 : d[L-1-i];
            else          fb[i] = (i < n) ? d[n-1-i] : 1'b0;
        end
        e0 = '0; e1 = '0;
        if (!du) begin
            e0 = fb; cyc = L;
        end else if (pm && bs) begin
            cyc = L / 2;
            for (int k = 0; k < cyc; k++) begin
                e1[k] = fb[k];
                e0[k] = fb[cyc + k];
            end
        end else begin
            cyc = (L + 1) / 2;
            for (int k = 0; k < cyc; k++) begin
                e1[k] = fb[2*k];
                e0[k] = (2*k + 1 < L) ? fb[2*k+1] : 1'b0;
            end
        end
    endfunction

    task automatic write_cfg(input logic [7:0] v, input logic unl);
        @(negedge clk);
        cfg_wdata = v; cfg_unlock = unl; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] c, input int n, input logic [31:0] d);
        logic [31:0] e0, e1, g0, g1;
        int cyc;
        bit early_done, oe_bad;
        string tag;
        model(c, n, d, e0, e1, cyc);
        tag = !c[2] ? "R7 R5 R6" : ((c[6] && c[4]) ? "R9 R5 R6" : "R8 R5 R6");
        write_cfg(c, 1'b1);
        check(cfg_rdata == (c & 8'h77), "R2", "cfg readback", {24'h0, cfg_rdata}, {24'h0, c & 8'h77});
        data_in = d; data_len = 6'(n); cs_n = 1'b0;
        @(negedge clk);
        g0 = '0; g1 = '0; early_done = 0; oe_bad = 0;
        for (int k = 0; k < cyc; k++) begin
            g0[k] = sdo[0]; g1[k] = sdo[1];
            if (frame_done) early_done = 1;
            if (!sdo_oe) oe_bad = 1;
            shift_stb = 1'b1;
            @(negedge clk);
            shift_stb = 1'b0;
        end
        check(g0 == e0, tag, "lane0 stream", g0, e0);
        check(g1 == e1, tag, "lane1 stream", g1, e1);
        check(!oe_bad, "R10", "drive enable during frame", {31'h0, oe_bad}, 32'h0);
        check(frame_done && !early_done && sdo == 2'b00, "R11", "done after last bit",
              {early_done, sdo, frame_done}, 32'h1);
        @(negedge clk);
        check(!frame_done && sdo == 2'b00, "R11", "done single cycle",
              {sdo, frame_done}, 32'h0);
        cs_n = 1'b1;
        @(negedge clk);
        check(!sdo_oe && sdo == 2'b00, "R12", "release after deselect", {sdo, sdo_oe}, 32'h0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles_run++;
            if (cycles_run > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog expired actual=%0d expected<=100000", cycles_run);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(cfg_rdata == 8'h00 && sdo == 2'b00 && !sdo_oe && !frame_done, "R1",
              "reset state", {cfg_rdata, sdo, sdo_oe, frame_done}, 32'h0);

        // R2: locked write ignored, then unlocked write stored with reserved bits cleared
        write_cfg(8'h44, 1'b0);
        check(cfg_rdata == 8'h00, "R2", "locked write", {24'h0, cfg_rdata}, 32'h0);
        write_cfg(8'hFF, 1'b1);
        check(cfg_rdata == 8'h77, "R2", "reserved bits", {24'h0, cfg_rdata}, 32'h77);

        // R3: unsupported protocol codes rejected
        write_cfg(8'h41, 1'b1);
        check(cfg_rdata == 8'h77, "R3", "code 01 rejected", {24'h0, cfg_rdata}, 32'h77);
        write_cfg(8'h06, 1'b1);
        check(cfg_rdata == 8'h77, "R3", "code 10 rejected", {24'h0, cfg_rdata}, 32'h77);
        write_cfg(8'h00, 1'b1);
        check(cfg_rdata == 8'h00, "R3", "code 00 stored", {24'h0, cfg_rdata}, 32'h0);

        // R4: write during an active frame ignored
        @(negedge clk);
        cs_n = 1'b0;
        write_cfg(8'h44, 1'b1);
        check(cfg_rdata == 8'h00, "R4", "write while selected", {24'h0, cfg_rdata}, 32'h0);
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R12
        check(!sdo_oe && sdo == 2'b00, "R12", "idle release", {sdo, sdo_oe}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            run_frame(VECS[v].cfg, int'(VECS[v].n), VECS[v].d);
        end

        // Corner cases: single-bit frame, full-width interleave, padded 16-bit boundary
        run_frame(8'h00, 1, 32'h1);
        run_frame(8'h04, 32, 32'h8000_0001);
        run_frame(8'h74, 16, 32'h0000_B1E5);
        run_frame(8'h64, 17, 32'h0001_5A5A);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule